// File: doc/BRIEF.md
# Tagged Byte FIFO Slice with Status Interrupt

This block is one byte-wide FIFO slice for a serial port. It can sit on the transmit side or the receive side. A producer pushes bytes through a data port and a consumer pops them one at a time. Each stored byte carries a one-bit end-of-frame tag. A frame boundary is marked by arming the tag with a command write before the next data write. The tag then travels with that byte to the consumer. Bus decoding is outside the block, so every register is reached through its own write strobe and read value. The serial engine is also outside the block.

A size field sets the usable capacity in units of four bytes, limited by the physical depth. A threshold register drives a level alarm, and the compare direction depends on the path type. Four sticky status bits report the following events:

- the FIFO draining to empty,
- the alarm condition,
- a write dropped because the FIFO was full,
- a read from an empty FIFO.

Software clears these bits by writing ones. An interrupt line is raised when any status bit is set together with its mask bit.

Top module: `tagged_fifo_slice`

## Requirements
- R1: After reset:
  - count is 0, the status bits are 0, the mask is 0 and irq is low;
  - the slice is disabled and no end-of-frame tag is armed;
  - the alarm is low and capacity equals DEPTH.
- R2: While the slice-enable bit is clear, pushes and pops have no effect. Count, read data and the status bits stay unchanged.
- R3: A push while count is at or above capacity is dropped. Count stays the same and status bit 2 (overflow) is set.
- R4: A pop from an empty FIFO returns data 0 with tag 0, leaves count at 0 and sets status bit 3 (underflow).
- R5: Bytes leave in the order they were accepted. Read data and its tag are registered and become valid the cycle after the pop. Count follows accepted pushes minus accepted pops.
- R6: The size field is 11 bits wide. Capacity is min(size×4, DEPTH), and size 0 gives capacity 0.
- R7: Command bit 2 arms an end-of-frame tag. The next accepted push stores the tag with its byte and disarms it. The tag is presented with that byte when it is popped, and untagged bytes pop with tag 0.
- R8: Command bit 3 empties the FIFO in one cycle:
  - count goes to 0, all tags clear and any armed tag is dropped;
  - a push or pop in that same cycle is ignored.
- R9: Status bit 0 (empty) is set in the cycle count goes from nonzero to zero. Writing 1 clears a status bit. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: irq is the OR of (status AND mask). A mask of 0 keeps irq low whatever the status.
- R11: The alarm output follows the threshold compare:
  - on the receive variant it is high while count > threshold, and on the transmit variant while count < threshold;
  - status bit 1 is set in every cycle the alarm is high;
  - the reset thresholds (0xFFF for receive, 0 for transmit) never trigger it.
- R12: A command write loads the slice-enable bit from bit 0 and the DMA-enable bit from bit 1. Both are visible on output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Write one byte to the data port |
| push_data_i | input | 8 | Byte to write |
| pop_i | input | 1 | Read one byte from the data port |
| pop_data_o | output | 8 | Byte read (registered) |
| pop_eof_o | output | 1 | End-of-frame tag of the byte read |
| cmd_we_i | input | 1 | Command register write |
| cmd_wdata_i | input | 4 | Bit 0 enable, bit 1 DMA enable, bit 2 arm end-of-frame, bit 3 flush |
| size_we_i | input | 1 | Size register write |
| size_wdata_i | input | 11 | Capacity in four-byte units |
| thr_we_i | input | 1 | Alarm threshold write |
| thr_wdata_i | input | 12 | Alarm threshold |
| isr_clr_we_i | input | 1 | Status write-one-to-clear strobe |
| isr_clr_i | input | 4 | Status bits to clear |
| imr_we_i | input | 1 | Mask register write |
| imr_wdata_i | input | 4 | Mask value |
| count_o | output | CNT_W (7) | Bytes held |
| capacity_o | output | CNT_W (7) | Effective capacity |
| isr_o | output | 4 | Status: 0 empty, 1 alarm, 2 overflow, 3 underflow |
| imr_o | output | 4 | Mask |
| slice_en_o | output | 1 | Slice enabled |
| dma_en_o | output | 1 | DMA enable bit |
| eof_pending_o | output | 1 | End-of-frame tag armed |
| alarm_o | output | 1 | Threshold alarm level |
| irq_o | output | 1 | Interrupt request |

## Verification
The main same-cycle collision is a clear of the empty bit arriving in the same cycle as the pop that drains the FIFO. The bench provokes it with a directed sequence: one push, then a pop combined with a write-one-to-clear of bit 0. It expects the bit to stay set, because set wins. Random traffic with a fixed seed then mixes status clears, end-of-frame arming, pushes at full and pops at empty against a small capacity, so clears meet fresh overflow, underflow and empty events. A bench model tracks count, status, data order and tags every cycle. The second collision is an end-of-frame arm in the same cycle as a push: the pushed byte takes the tag that was already armed, and the new one stays armed for the following byte.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    localparam int NST     = 4;
    localparam int ST_EMPTY = 0;
    localparam int ST_ALARM = 1;
    localparam int ST_OVF   = 2;
    localparam int ST_UNF   = 3;

    localparam int CMD_EN  = 0;
    localparam int CMD_DMA = 1;
    localparam int CMD_EOF = 2;
    localparam int CMD_RST = 3;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } slot_t;

    function automatic logic [12:0] size_to_bytes(input logic [10:0] sz);
        return {sz, 2'b00};
    endfunction

endpackage

// File: rtl/tfifo_store.sv
module tfifo_store
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic [CW-1:0] cap_i,
    input  logic          push_i,
    input  slot_t         wslot_i,
    input  logic          pop_i,
    output slot_t         rslot_o,
    output logic [CW-1:0] count_o,
    output logic          acc_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          drained_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       data_mem [DEPTH];
    logic [DEPTH-1:0] tag_q;
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    count_q, count_n;
    logic             full, empty, act, push_ok, pop_ok;

    assign act     = en_i && !clr_i;
    assign full    = count_q >= cap_i;
    assign empty   = count_q == '0;
    assign push_ok = act && push_i && !full;
    assign pop_ok  = act && pop_i && !empty;

    assign acc_o   = push_ok;
    assign ovf_o   = act && push_i && full;
    assign unf_o   = act && pop_i && empty;

    always_comb begin
        if (clr_i) count_n = '0;
        else       count_n = count_q + CW'(push_ok) - CW'(pop_ok);
    end

    assign drained_o = (count_q != '0) && (count_n == '0);
    assign count_o   = count_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) data_mem[wr_q] <= wslot_i.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            tag_q   <= '0;
            rslot_o <= '0;
        end else if (clr_i) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            tag_q   <= '0;
        end else begin
            count_q <= count_n;
            if (push_ok) begin
                tag_q[wr_q] <= wslot_i.eof;
                wr_q        <= nxt(wr_q);
            end
            if (pop_ok) rd_q <= nxt(rd_q);
            if (act && pop_i)
                rslot_o <= pop_ok ? slot_t'({tag_q[rd_q], data_mem[rd_q]}) : slot_t'('0);
        end
    end

    // R2: a disabled slice keeps its occupancy and read data
    p_off_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> ($stable(count_q) && $stable(rslot_o)));

    // R3: a push at full leaves the occupancy untouched
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i && push_i && !pop_i && count_q >= cap_i) |=> $stable(count_q));

    // R4: an empty read yields zero data and zero tag
    p_unf_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i && pop_i && count_q == '0) |=> (rslot_o == '0));

    // R8: flush empties storage and tags
    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_q == '0 && tag_q == '0));

endmodule

// File: rtl/tfifo_irq.sv
module tfifo_irq
    import tfifo_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NST-1:0] set_i,
    input  logic           clr_we_i,
    input  logic [NST-1:0] clr_mask_i,
    input  logic           imr_we_i,
    input  logic [NST-1:0] imr_i,
    output logic [NST-1:0] isr_o,
    output logic [NST-1:0] imr_o,
    output logic           irq_o
);

    logic [NST-1:0] isr_q, imr_q, wipe;

    assign wipe = clr_we_i ? clr_mask_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            imr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~wipe) | set_i;
            if (imr_we_i) imr_q <= imr_i;
        end
    end

    assign isr_o = isr_q;
    assign imr_o = imr_q;
    assign irq_o = |(isr_q & imr_q);

    // R9: a drain event always lands in the status register
    p_empty_set_r9: assert property (@(posedge clk) disable iff (rst)
        set_i[ST_EMPTY] |=> isr_q[ST_EMPTY]);

    // R9: write-one-to-clear without a competing set clears the bit
    p_empty_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_we_i && clr_mask_i[ST_EMPTY] && !set_i[ST_EMPTY]) |=> !isr_q[ST_EMPTY]);

endmodule

// File: rtl/tagged_fifo_slice.sv
module tagged_fifo_slice
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter bit IS_RX = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [7:0]       push_data_i,
    input  logic             pop_i,
    output logic [7:0]       pop_data_o,
    output logic             pop_eof_o,
    input  logic             cmd_we_i,
    input  logic [3:0]       cmd_wdata_i,
    input  logic             size_we_i,
    input  logic [10:0]      size_wdata_i,
    input  logic             thr_we_i,
    input  logic [11:0]      thr_wdata_i,
    input  logic             isr_clr_we_i,
    input  logic [3:0]       isr_clr_i,
    input  logic             imr_we_i,
    input  logic [3:0]       imr_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capacity_o,
    output logic [3:0]       isr_o,
    output logic [3:0]       imr_o,
    output logic             slice_en_o,
    output logic             dma_en_o,
    output logic             eof_pending_o,
    output logic             alarm_o,
    output logic             irq_o
);

    localparam logic [12:0] DEPTH13 = 13'(DEPTH);
    localparam logic [11:0] THR_RST = IS_RX ? 12'hFFF : 12'h000;

    logic        en_q, dma_q, eof_q;
    logic [10:0] size_q;
    logic [11:0] thr_q;
    logic [12:0] bytes;
    logic        clr, acc, ovf, unf, drained;
    slot_t       wslot, rslot;
    logic [NST-1:0] set_vec;

    assign clr   = cmd_we_i && cmd_wdata_i[CMD_RST];
    assign bytes = size_to_bytes(size_q);
    assign capacity_o = (bytes > DEPTH13) ? CNT_W'(DEPTH) : CNT_W'(bytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            dma_q  <= 1'b0;
            eof_q  <= 1'b0;
            size_q <= 11'(DEPTH / 4);
            thr_q  <= THR_RST;
        end else begin
            if (cmd_we_i) begin
                en_q  <= cmd_wdata_i[CMD_EN];
                dma_q <= cmd_wdata_i[CMD_DMA];
            end
            if (clr)                                eof_q <= 1'b0;
            else if (cmd_we_i && cmd_wdata_i[CMD_EOF]) eof_q <= 1'b1;
            else if (acc)                           eof_q <= 1'b0;
            if (size_we_i) size_q <= size_wdata_i;
            if (thr_we_i)  thr_q  <= thr_wdata_i;
        end
    end

    assign wslot = '{eof: eof_q, data: push_data_i};

    tfifo_store #(.DEPTH(DEPTH), .CW(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_q),
        .clr_i     (clr),
        .cap_i     (capacity_o),
        .push_i    (push_i),
        .wslot_i   (wslot),
        .pop_i     (pop_i),
        .rslot_o   (rslot),
        .count_o   (count_o),
        .acc_o     (acc),
        .ovf_o     (ovf),
        .unf_o     (unf),
        .drained_o (drained)
    );

    generate
        if (IS_RX) begin : g_rx_alarm
            assign alarm_o = 12'(count_o) > thr_q;
        end else begin : g_tx_alarm
            assign alarm_o = 12'(count_o) < thr_q;
        end
    endgenerate

    always_comb begin
        set_vec           = '0;
        set_vec[ST_EMPTY] = drained;
        set_vec[ST_ALARM] = alarm_o;
        set_vec[ST_OVF]   = ovf;
        set_vec[ST_UNF]   = unf;
    end

    tfifo_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_vec),
        .clr_we_i   (isr_clr_we_i),
        .clr_mask_i (isr_clr_i),
        .imr_we_i   (imr_we_i),
        .imr_i      (imr_wdata_i),
        .isr_o      (isr_o),
        .imr_o      (imr_o),
        .irq_o      (irq_o)
    );

    assign pop_data_o    = rslot.data;
    assign pop_eof_o     = rslot.eof;
    assign slice_en_o    = en_q;
    assign dma_en_o      = dma_q;
    assign eof_pending_o = eof_q;

    // R7: arming the end-of-frame bit leaves it pending next cycle
    p_eof_arm_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_we_i && cmd_wdata_i[CMD_EOF] && !cmd_wdata_i[CMD_RST]) |=> eof_pending_o);

    // R12: a command write lands in the enable bits
    p_cmd_en_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_we_i |=> (slice_en_o == $past(cmd_wdata_i[CMD_EN])
                      && dma_en_o == $past(cmd_wdata_i[CMD_DMA])));

endmodule

// File: tb/sim_tagged_fifo_slice.sv
`timescale 1ns/1ps
module sim_tagged_fifo_slice;

    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic push_i = 0, pop_i = 0, cmd_we_i = 0, size_we_i = 0, thr_we_i = 0;
    logic isr_clr_we_i = 0, imr_we_i = 0;
    logic [7:0] push_data_i = 0;
    logic [3:0] cmd_wdata_i = 0, isr_clr_i = 0, imr_wdata_i = 0;
    logic [10:0] size_wdata_i = 0;
    logic [11:0] thr_wdata_i = 0;
    logic [7:0] pop_data_o;
    logic pop_eof_o, slice_en_o, dma_en_o, eof_pending_o, alarm_o, irq_o;
    logic [CW-1:0] count_o, capacity_o;
    logic [3:0] isr_o, imr_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tagged_fifo_slice #(.DEPTH(DEPTH), .IS_RX(1'b1)) u0 (.*);

    function automatic int exp_cap(input int sz);
        return (sz * 4 > DEPTH) ? DEPTH : sz * 4;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        push_i = 0; pop_i = 0; cmd_we_i = 0; size_we_i = 0; thr_we_i = 0;
        isr_clr_we_i = 0; imr_we_i = 0;
    endtask

    task automatic cmd(input logic [3:0] v);
        cmd_we_i = 1; cmd_wdata_i = v; tick();
    endtask
    task automatic w1c(input logic [3:0] m);
        isr_clr_we_i = 1; isr_clr_i = m; tick();
    endtask
    task automatic push(input logic [7:0] d);
        push_i = 1; push_data_i = d; tick();
    endtask
    task automatic pop();
        pop_i = 1; tick();
    endtask
    task automatic set_size(input logic [10:0] s);
        size_we_i = 1; size_wdata_i = s; tick();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] q[$];
        int cnt, cap, pend;
        logic [3:0] misr;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 isr", isr_o, 0);
        chk("R1 imr", imr_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 slice", slice_en_o, 0);
        chk("R1 pend", eof_pending_o, 0);
        chk("R1 alarm", alarm_o, 0);
        chk("R1 cap", capacity_o, DEPTH);

        // R2 disabled slice ignores traffic
        push(8'h11);
        chk("R2 count", count_o, 0);
        pop();
        chk("R2 isr", isr_o, 0);
        chk("R2 data", pop_data_o, 0);

        // R12 enable bits
        cmd(4'b0001);
        chk("R12 en", slice_en_o, 1);
        chk("R12 dma0", dma_en_o, 0);
        cmd(4'b0011);
        chk("R12 dma1", dma_en_o, 1);

        // R4 underflow
        pop();
        chk("R4 data", pop_data_o, 0);
        chk("R4 eof", pop_eof_o, 0);
        chk("R4 isr", isr_o, 4'b1000);
        chk("R4 count", count_o, 0);
        w1c(4'hF);
        chk("R9 w1c all", isr_o, 0);

        // R6 capacity
        set_size(11'd1);
        chk("R6 cap1", capacity_o, exp_cap(1));
        set_size(11'd0);
        chk("R6 cap0", capacity_o, 0);
        push(8'h22);
        chk("R3 cap0 count", count_o, 0);
        chk("R3 cap0 ovf", isr_o, 4'b0100);
        set_size(11'd2047);
        chk("R6 capmax", capacity_o, exp_cap(2047));
        set_size(11'd1);
        w1c(4'hF);

        // R3 overflow at capacity 4
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        chk("R3 count", count_o, 4);
        chk("R3 isr", isr_o, 4'b0100);
        w1c(4'hF);

        // R5 order, R9 drain
        for (int i = 0; i < 4; i++) begin
            pop();
            chk("R5 data", pop_data_o, 8'hA0 + 8'(i));
            chk("R5 count", count_o, 3 - i);
        end
        chk("R9 empty set", isr_o, 4'b0001);
        w1c(4'h1);
        chk("R9 cleared", isr_o, 0);

        // R9 collision: drain and clear in one cycle
        push(8'h5A);
        pop_i = 1; isr_clr_we_i = 1; isr_clr_i = 4'h1; tick();
        chk("R9 set wins", isr_o[0], 1);
        chk("R5 single", pop_data_o, 8'h5A);
        w1c(4'h1);
        chk("R9 clr", isr_o, 0);

        // R10 masking
        pop();
        chk("R10 mask0", irq_o, 0);
        imr_we_i = 1; imr_wdata_i = 4'b0111; tick();
        chk("R10 masked", irq_o, 0);
        imr_we_i = 1; imr_wdata_i = 4'b1000; tick();
        chk("R10 raised", irq_o, 1);
        w1c(4'hF);
        chk("R10 cleared", irq_o, 0);
        imr_we_i = 1; imr_wdata_i = 4'h0; tick();

        // R7 end-of-frame tag
        set_size(11'd2047);
        cmd(4'b0111);
        chk("R7 armed", eof_pending_o, 1);
        push(8'hB1);
        chk("R7 disarmed", eof_pending_o, 0);
        push(8'hC2);
        pop();
        chk("R7 tag data", pop_data_o, 8'hB1);
        chk("R7 tag", pop_eof_o, 1);
        pop();
        chk("R7 plain data", pop_data_o, 8'hC2);
        chk("R7 plain", pop_eof_o, 0);
        w1c(4'hF);

        // R11 alarm
        thr_we_i = 1; thr_wdata_i = 12'd2; tick();
        push(8'h01); push(8'h02);
        chk("R11 at thr", alarm_o, 0);
        push(8'h03);
        chk("R11 above", alarm_o, 1);
        tick();
        chk("R11 status", isr_o[1], 1);
        thr_we_i = 1; thr_wdata_i = 12'hFFF; tick();
        chk("R11 off", alarm_o, 0);
        w1c(4'hF);

        // R8 flush with simultaneous push
        cmd_we_i = 1; cmd_wdata_i = 4'b1101; push_i = 1; push_data_i = 8'h77; tick();
        chk("R8 count", count_o, 0);
        chk("R8 pend", eof_pending_o, 0);
        chk("R8 empty", isr_o, 4'b0001);
        push(8'h33);
        pop();
        chk("R8 data", pop_data_o, 8'h33);
        chk("R8 tag", pop_eof_o, 0);
        w1c(4'hF);

        // random phase against a model
        set_size(11'd3);
        imr_we_i = 1; imr_wdata_i = 4'hF; tick();
        cap = 12; cnt = 0; pend = 0; misr = 0;
        for (int k = 0; k < 3000; k++) begin
            logic dp, dq, de, dc;
            logic [3:0] m;
            logic [8:0] got;
            int ncnt;
            logic [3:0] setv;
            dp = ($urandom % 100) < 55;
            dq = ($urandom % 100) < 45;
            de = ($urandom % 100) < 8;
            dc = ($urandom % 100) < 10;
            m  = 4'($urandom);
            push_i = dp; push_data_i = 8'($urandom);
            pop_i = dq; cmd_we_i = de; cmd_wdata_i = 4'b0101;
            isr_clr_we_i = dc; isr_clr_i = m;
            setv = 0; got = 0; ncnt = cnt;
            if (dq && cnt == 0) setv[3] = 1;
            if (dq && cnt > 0) begin got = q.pop_front(); ncnt--; end
            if (dp && cnt >= cap) setv[2] = 1;
            if (dp && cnt < cap) begin q.push_back({pend[0], push_data_i}); ncnt++; end
            if (de) pend = 1; else if (dp && cnt < cap) pend = 0;
            if (cnt > 0 && ncnt == 0) setv[0] = 1;
            misr = (misr & ~(dc ? m : 4'h0)) | setv;
            cnt = ncnt;
            tick();
            chk("R5 rnd count", count_o, cnt);
            chk("R9 rnd isr", isr_o, misr);
            chk("R10 rnd irq", irq_o, |misr);
            chk("R7 rnd pend", eof_pending_o, pend);
            if (dq) chk("R5 rnd data", {pop_eof_o, pop_data_o}, got);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule